// File: doc/BRIEF.md
# Errored Event Counter with Threshold Alarm

This block tallies errored events seen by a receive link in two independent channels. Channel 0 counts failed cell-header checksums and channel 1 counts failed parity bytes. Each channel gets a one-cycle error strobe from the checking logic upstream, keeps a saturating count, and compares that count with a threshold that software programs.

Software reaches the block through a byte-wide register port. Reading a count's low byte takes a coherent snapshot of the whole count and clears the live counter. The middle and high bytes then return the snapshot. When a count rises above its threshold, a sticky alarm bit is set. Each alarm bit can drive the interrupt line through its own mask bit.

Register offsets, byte lane 0 being bits 7:0:

| Offset | Contents |
|---|---|
| 0x00 / 0x08 | Header / parity count, low byte |
| 0x01 / 0x09 | Header / parity count, middle byte |
| 0x02 / 0x0A | Header / parity count, high byte |
| 0x03-0x05 / 0x0B-0x0D | Header / parity threshold, low, middle, high |
| 0x10 | Alarm register |
| 0x11 | Interrupt mask |

Top module: `errcnt_monitor`

## Requirements
- R1: Each cycle with `hdr_err_i` high adds 1 to the header count, and each cycle with `par_err_i` high adds 1 to the parity count. The two counts are independent.
- R2: Reading offset 0x00 (header) or 0x08 (parity) returns bits 7:0 of the live count and captures the whole count into a snapshot. Offsets 0x01/0x09 return snapshot bits 15:8 and offsets 0x02/0x0A return snapshot bits 23:16. Error strobes that arrive after the capture do not change these bytes.
- R3: A read of a low count byte clears that count. An error strobe in the same cycle as that read leaves the count at 1.
- R4: A count saturates at all ones (0xFFFFFF by default) and does not wrap.
- R5: The thresholds are writable and readable at offsets 0x03/0x04/0x05 (header: low, middle, high) and 0x0B/0x0C/0x0D (parity). Both reset to 0xFFFFFF.
- R6: Alarm register 0x10 holds bit 0 for header and bit 1 for parity. A bit is set in the cycle after its count becomes strictly greater than its threshold, so a count equal to the threshold raises nothing.
- R7: Alarm bits are sticky. A read of 0x10 returns them and then clears them, but a bit whose count still exceeds its threshold is set again.
- R8: Mask register 0x11 holds bit 0 for header and bit 1 for parity (1 = enabled). It resets to 0. `irq_o` is high while any alarm bit is set together with its mask bit.
- R9: After reset, the counts, alarms and `irq_o` are 0. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| hdr_err_i | input | 1 | Header checksum error strobe |
| par_err_i | input | 1 | Parity byte error strobe |
| reg_addr_i | input | 5 | Register offset |
| reg_rd_i | input | 1 | Read strobe; side effects at the clock edge |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from offset |
| irq_o | output | 1 | Interrupt, masked OR of alarm bits |

## Verification
A table of vectors pairs thresholds with burst lengths for each channel: bursts just below, at and just above the threshold, a zero threshold, a threshold that sits only in the middle byte, and the all-ones threshold. These separate a strict comparison from greater-or-equal, show whether the channels leak into each other, and show whether all threshold bytes take part in the compare. Directed runs drive a count past 255 and strobe again between the byte reads to tell a snapshot from live reads. They also put an error strobe in the same cycle as a clearing read, and run an 8-bit instance past its limit to show saturation against wrap. A further test shows that an alarm stays latched after its cause is gone, and another checks the interrupt with its mask bit off and on.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;
  localparam int          NUM_SRC    = 2;
  localparam int          REG_AW     = 5;
  localparam int          REG_BYTES  = 3;
  localparam int          EXT_W      = REG_BYTES * 8;
  localparam logic [4:0]  A_HDR_BASE = 5'h00;
  localparam logic [4:0]  A_PAR_BASE = 5'h08;
  localparam logic [4:0]  A_ALARM    = 5'h10;
  localparam logic [4:0]  A_MASK     = 5'h11;
  localparam logic [4:0]  OFF_THR    = 5'h03;

  function automatic logic [7:0] lane_of(input logic [EXT_W-1:0] v, input int idx);
    return v[idx*8 +: 8];
  endfunction
endpackage

// File: rtl/errcnt_chan.sv
module errcnt_chan #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             cap_i,
  input  logic             thr_we_i,
  input  logic [1:0]       thr_sel_i,
  input  logic [7:0]       thr_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] snap_o,
  output logic [CNT_W-1:0] thr_o,
  output logic             over_o
);
  import errcnt_pkg::*;
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, snap_q, thr_q;
  logic [EXT_W-1:0] thr_ext, thr_nxt;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic hit, input logic clr);
    if (clr)                    return {{(CNT_W-1){1'b0}}, hit};
    else if (hit && cur != MAX) return cur + 1'b1;
    else                        return cur;
  endfunction

  always_comb begin
    thr_ext = EXT_W'(thr_q);
    thr_nxt = thr_ext;
    thr_nxt[thr_sel_i*8 +: 8] = thr_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
      thr_q  <= MAX;
    end else begin
      cnt_q <= next_count(cnt_q, strobe_i, cap_i);
      if (cap_i)    snap_q <= cnt_q;
      if (thr_we_i) thr_q  <= thr_nxt[CNT_W-1:0];
    end
  end

  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;
  assign thr_o  = thr_q;
  assign over_o = cnt_q > thr_q;

  // R1
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_i && strobe_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> cnt_q == {{(CNT_W-1){1'b0}}, $past(strobe_i)});
  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_i && cnt_q == MAX) |=> cnt_q == MAX);
  // R2
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(snap_q));
endmodule

// File: rtl/errcnt_alarm.sv
module errcnt_alarm #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] alarm_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] alarm_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= '0;
      mask_q  <= '0;
    end else begin
      alarm_q <= (clr_i ? '0 : alarm_q) | set_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign alarm_o = alarm_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(alarm_q & mask_q);

  // R6
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (alarm_q & $past(set_i)) == $past(set_i));
  // R7
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (alarm_q & $past(alarm_q)) == $past(alarm_q));
endmodule

// File: rtl/errcnt_monitor.sv
module errcnt_monitor #(
  parameter int CNT_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_err_i,
  input  logic       par_err_i,
  input  logic [4:0] reg_addr_i,
  input  logic       reg_rd_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o
);
  import errcnt_pkg::*;

  logic [NUM_SRC-1:0] src_err, over_w, alarm_w, mask_w;
  logic [CNT_W-1:0]   cnt_w  [NUM_SRC];
  logic [CNT_W-1:0]   snap_w [NUM_SRC];
  logic [CNT_W-1:0]   thr_w  [NUM_SRC];
  logic               alarm_rd, mask_wr;

  assign src_err  = {par_err_i, hdr_err_i};
  assign alarm_rd = reg_rd_i && reg_addr_i == A_ALARM;
  assign mask_wr  = reg_wr_i && reg_addr_i == A_MASK;

  for (genvar c = 0; c < NUM_SRC; c++) begin : g_chan
    localparam logic [4:0] BASE = (c == 0) ? A_HDR_BASE : A_PAR_BASE;
    logic [4:0] off;
    logic       cap, thr_we;
    logic [1:0] sel;
    assign off    = reg_addr_i - BASE;
    assign cap    = reg_rd_i && off == 5'd0;
    assign thr_we = reg_wr_i && off >= OFF_THR && off < OFF_THR + 5'd3;
    assign sel    = off[1:0] + 2'd1;
    errcnt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .strobe_i(src_err[c]), .cap_i(cap),
      .thr_we_i(thr_we), .thr_sel_i(sel), .thr_wdata_i(reg_wdata_i),
      .cnt_o(cnt_w[c]), .snap_o(snap_w[c]), .thr_o(thr_w[c]), .over_o(over_w[c]));
  end

  errcnt_alarm #(.N(NUM_SRC)) u_alarm (
    .clk(clk), .rst_n(rst_n), .set_i(over_w), .clr_i(alarm_rd),
    .mask_we_i(mask_wr), .mask_wdata_i(reg_wdata_i[NUM_SRC-1:0]),
    .alarm_o(alarm_w), .mask_o(mask_w), .irq_o(irq_o));

  always_comb begin
    reg_rdata_o = 8'h00;
    for (int c = 0; c < NUM_SRC; c++) begin
      logic [4:0] base;
      base = (c == 0) ? A_HDR_BASE : A_PAR_BASE;
      if (reg_addr_i == base)        reg_rdata_o = lane_of(EXT_W'(cnt_w[c]), 0);
      if (reg_addr_i == base + 5'd1) reg_rdata_o = lane_of(EXT_W'(snap_w[c]), 1);
      if (reg_addr_i == base + 5'd2) reg_rdata_o = lane_of(EXT_W'(snap_w[c]), 2);
      for (int k = 0; k < REG_BYTES; k++)
        if (reg_addr_i == base + OFF_THR + 5'(k))
          reg_rdata_o = lane_of(EXT_W'(thr_w[c]), k);
    end
    if (reg_addr_i == A_ALARM) reg_rdata_o = 8'(alarm_w);
    if (reg_addr_i == A_MASK)  reg_rdata_o = 8'(mask_w);
  end

  // R9
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (alarm_w == '0 && !irq_o));
endmodule

// File: tb/errcnt_monitor_tb.sv
module errcnt_monitor_tb;
  logic clk = 0, rst_n = 0;
  logic hdr_err = 0, par_err = 0, sat_err = 0;
  logic [4:0] addr = 0;
  logic rd = 0, wr = 0;
  logic [7:0] wdata = 0, rdata, rdata_sat;
  logic irq, irq_sat;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  errcnt_monitor u_dut (.clk(clk), .rst_n(rst_n), .hdr_err_i(hdr_err), .par_err_i(par_err),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq));
  errcnt_monitor #(.CNT_W(8)) u_dut_sat (.clk(clk), .rst_n(rst_n), .hdr_err_i(sat_err),
    .par_err_i(1'b0), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_sat), .irq_o(irq_sat));

  // channel, threshold, burst length
  localparam logic [32:0] VEC [7] = '{
    {1'b0, 24'd3,      8'd3},
    {1'b0, 24'd3,      8'd4},
    {1'b1, 24'd0,      8'd1},
    {1'b1, 24'd0,      8'd0},
    {1'b0, 24'h000100, 8'd20},
    {1'b1, 24'd5,      8'd9},
    {1'b0, 24'hFFFFFF, 8'd7}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d, output logic [7:0] ds);
    @(negedge clk); addr = a; rd = 1;
    #2 d = rdata; ds = rdata_sat;
    @(posedge clk); #1 rd = 0;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(posedge clk); #1 wr = 0;
  endtask

  task automatic pulse(input int ch, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ch == 0) hdr_err = 1; else if (ch == 1) par_err = 1; else sat_err = 1;
    end
    @(negedge clk); hdr_err = 0; par_err = 0; sat_err = 0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, ds;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 irq after reset", irq, 0);
    rd_reg(5'h10, d, ds); chk("R9 alarm after reset", d, 0);
    rd_reg(5'h00, d, ds); chk("R9 header count after reset", d, 0);
    rd_reg(5'h08, d, ds); chk("R9 parity count after reset", d, 0);
    rd_reg(5'h1F, d, ds); chk("R9 unmapped reads 0", d, 0);
    rd_reg(5'h05, d, ds); chk("R5 threshold reset high byte", d, 8'hFF);
    rd_reg(5'h0B, d, ds); chk("R5 threshold reset low byte", d, 8'hFF);
    rd_reg(5'h11, d, ds); chk("R8 mask reset", d, 0);

    // R1 R5 R6 vector table
    for (int v = 0; v < 7; v++) begin
      logic        ch;
      logic [23:0] thr;
      logic [7:0]  n;
      logic [4:0]  base, other;
      ch = VEC[v][32]; thr = VEC[v][31:8]; n = VEC[v][7:0];
      base = ch ? 5'h08 : 5'h00; other = ch ? 5'h00 : 5'h08;
      for (int k = 0; k < 3; k++) wr_reg(base + 5'd3 + 5'(k), thr[k*8 +: 8]);
      rd_reg(base + 5'd5, d, ds); chk("R5 threshold readback", d, thr[23:16]);
      rd_reg(5'h00, d, ds); rd_reg(5'h08, d, ds);
      rd_reg(5'h10, d, ds);
      pulse(ch, n);
      rd_reg(5'h10, d, ds);
      chk("R6 alarm strictly above threshold", d[ch], 32'(n > thr));
      chk("R1 other channel alarm untouched", d[~ch], 0);
      rd_reg(base, d, ds);           chk("R1 count low byte", d, n);
      rd_reg(base + 5'd1, d, ds);    chk("R2 count mid byte", d, 0);
      rd_reg(other, d, ds);          chk("R1 other channel count", d, 0);
    end
    rd_reg(5'h10, d, ds);

    // R2 snapshot across byte reads
    pulse(0, 300);
    rd_reg(5'h00, d, ds); chk("R2 low byte of 300", d, 8'h2C);
    pulse(0, 2);
    rd_reg(5'h01, d, ds); chk("R2 mid byte from snapshot", d, 8'h01);
    rd_reg(5'h02, d, ds); chk("R2 high byte from snapshot", d, 8'h00);
    rd_reg(5'h00, d, ds); chk("R3 count restarted after read", d, 2);

    // R3 strobe coincident with clearing read
    pulse(1, 5);
    @(negedge clk); addr = 5'h08; rd = 1; par_err = 1;
    #2 d = rdata;
    @(posedge clk); #1 rd = 0; par_err = 0;
    chk("R3 read shows count before clear", d, 5);
    rd_reg(5'h08, d, ds); chk("R3 coincident strobe counted as 1", d, 1);

    // R4 saturation on 8-bit instance
    pulse(2, 300);
    rd_reg(5'h00, d, ds); chk("R4 saturated count", ds, 8'hFF);
    rd_reg(5'h01, d, ds); chk("R4 no carry into mid byte", ds, 8'h00);

    // R7 sticky alarm
    wr_reg(5'h03, 8'h00); wr_reg(5'h04, 8'h00); wr_reg(5'h05, 8'h00);
    rd_reg(5'h00, d, ds); rd_reg(5'h10, d, ds);
    pulse(0, 1);
    rd_reg(5'h00, d, ds); chk("R7 count of one", d, 1);
    @(negedge clk);
    rd_reg(5'h10, d, ds); chk("R7 alarm latched after cause gone", d, 8'h01);
    rd_reg(5'h10, d, ds); chk("R7 alarm cleared by read", d, 8'h00);

    // R8 interrupt mask
    pulse(0, 1);
    chk("R8 irq masked", irq, 0);
    wr_reg(5'h11, 8'h01);
    #2 chk("R8 irq enabled", irq, 1);
    rd_reg(5'h11, d, ds); chk("R8 mask readback", d, 8'h01);
    wr_reg(5'h11, 8'h02);
    #2 chk("R8 irq with other bit only", irq, 0);
    rd_reg(5'h00, d, ds); rd_reg(5'h10, d, ds);
    wr_reg(5'h11, 8'h01);
    #2 chk("R8 irq low after alarm cleared", irq, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule